// File: doc/BRIEF.md
# Finished Store Buffer with Free-List Slot Management

This block holds in-flight stores from the moment they are scheduled until they retire. It does not keep them in program order. A store asks for a slot when the scheduler picks it. The block takes the lowest-numbered free slot from a free-slot bit vector and returns that slot number one cycle later. The reorder logic keeps the number and later presents it to release the slot directly, with no search. Address and data arrive later on an execute-write port, which marks the slot as finished. All slot contents are brought out in parallel for an external forwarding unit.

Slot position says nothing about age, so each store carries an age colour. A branch-mispredict flush gives a boundary colour, and every occupied slot whose colour is younger than that boundary is dropped in one cycle. One slot is always held back for the oldest store in the window. A younger store may not take the last free slot, so the oldest store can never be blocked and the pipeline cannot deadlock.

Top module: `finished_store_buffer`

## Requirements
- R1: After reset, every slot is free: `slot_busy` and `slot_done` are all zero, `alloc_gnt` and `retire_err` are 0, and both permit outputs are 1.
- R2: A granted allocation takes the lowest-numbered free slot. `alloc_gnt` is 1 and `alloc_idx` gives that slot in the cycle after the request. From that cycle the slot is busy, holds the request colour in `slot_color`, and has `slot_done` at 0.
- R3: `permit_young` is 1 only when at least two slots are free, and `permit_oldest` is 1 when at least one slot is free. A request with `alloc_oldest`=0 is granted only when `permit_young` is 1. A request with `alloc_oldest`=1 is granted only when `permit_oldest` is 1.
- R4: An execute write to a busy slot stores the address and data and sets `slot_done` from the next cycle. A write to a free slot changes neither the address, the data nor `slot_done`.
- R5: A retire with the index of a busy slot frees that slot in the next cycle and clears its done bit. The slot can then be allocated again.
- R6: A retire with the index of a free slot sets `retire_err`. The flag stays set until reset, and the retire changes no slot.
- R7: A flush frees, in the next cycle, every busy slot whose colour c satisfies (c - boundary) mod 2^CW in 1 .. 2^(CW-1)-1. Slots with an equal or older colour stay. No allocation is granted in a flush cycle.
- R8: An allocation and a retire in the same cycle both take effect. The allocation chooses only among slots that were free before that cycle.
- R9: With no free slot, both permits are 0 and no request is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_req | input | 1 | Slot request from the scheduler |
| alloc_oldest | input | 1 | Requesting store is the oldest in the window |
| alloc_color | input | CW | Age colour of the requesting store |
| alloc_gnt | output | 1 | Registered grant for last cycle's request |
| alloc_idx | output | IW | Slot number of the grant |
| permit_young | output | 1 | A store that is not the oldest may issue |
| permit_oldest | output | 1 | The oldest store may issue |
| wr_en | input | 1 | Execute write strobe |
| wr_idx | input | IW | Slot written |
| wr_addr | input | AW | Store address |
| wr_data | input | DW | Store data |
| ret_en | input | 1 | Retire strobe |
| ret_idx | input | IW | Slot to release |
| flush_en | input | 1 | Mispredict flush strobe |
| flush_color | input | CW | Flush boundary colour |
| slot_busy | output | N | Per-slot occupied flag |
| slot_done | output | N | Per-slot finished flag |
| slot_color | output | N*CW | Per-slot colour, slot i at bits i*CW |
| slot_addr | output | N*AW | Per-slot address, slot i at bits i*AW |
| slot_data | output | N*DW | Per-slot data, slot i at bits i*DW |
| retire_err | output | 1 | Sticky invalid-retire flag |

## Verification
Some rules are checked by the assertions on every cycle: the reserve rule, the empty-buffer refusal, the one-cycle release of a retired slot, the frozen free vector after a bad retire, the per-slot flush kill and the stickiness of the error flag. Other behaviour needs the bench's scenarios to show it. These are the lowest-index choice over a whole fill, colour comparison across the wrap point, the ignored write to a free slot, and the same-cycle allocate and retire where the slot being freed must not be handed out.

// File: rtl/fsb_pkg.sv
package fsb_pkg;

  localparam int unsigned COLOR_MAX_W = 16;

  // True when colour c is younger than boundary b on a wrapping circle of 2^cw.
  function automatic logic color_younger(input logic [COLOR_MAX_W-1:0] c,
                                         input logic [COLOR_MAX_W-1:0] b,
                                         input int unsigned cw);
    logic [COLOR_MAX_W-1:0] mask;
    logic [COLOR_MAX_W-1:0] diff;
    mask = (COLOR_MAX_W'(1) << cw) - COLOR_MAX_W'(1);
    diff = (c - b) & mask;
    return (diff != '0) && !diff[cw-1];
  endfunction

endpackage

// File: rtl/fsb_pick.sv
module fsb_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req,
  output logic          found,
  output logic [N-1:0]  onehot,
  output logic [IW-1:0] idx
);

  logic [N:0] seen;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign onehot[i]  = req[i] & ~seen[i];
    assign seen[i+1]  = seen[i] | req[i];
  end

  assign found = seen[N];

  always_comb begin
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (onehot[i]) idx = IW'(i);
    end
  end

  always_comb begin
    a_pick_onehot_r2: assert ($onehot0(onehot));
  end

endmodule

// File: rtl/fsb_freelist.sv
module fsb_freelist #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  alloc_oh,
  input  logic          ret_en,
  input  logic [IW-1:0] ret_idx,
  input  logic [N-1:0]  kill,
  output logic [N-1:0]  free_q,
  output logic [N-1:0]  rel_oh,
  output logic          bad_retire,
  output logic          any_free,
  output logic          two_free
);

  logic ret_in_range;
  logic ret_hits_busy;

  always_comb begin
    ret_in_range  = (32'(ret_idx) < N);
    ret_hits_busy = ret_in_range && !free_q[ret_idx];
    rel_oh        = '0;
    if (ret_en && ret_hits_busy) rel_oh[ret_idx] = 1'b1;
    bad_retire    = ret_en && !ret_hits_busy;
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= '1;
    else     free_q <= (free_q | rel_oh | kill) & ~alloc_oh;
  end

  assign any_free = |free_q;
  assign two_free = |(free_q & (free_q - {{(N-1){1'b0}}, 1'b1}));

  p_release_r5: assert property (@(posedge clk) disable iff (rst)
    (ret_en && ret_hits_busy) |=> free_q[$past(ret_idx)]);

  p_bad_retire_frozen_r6: assert property (@(posedge clk) disable iff (rst)
    (bad_retire && alloc_oh == '0 && kill == '0) |=> $stable(free_q));

  p_alloc_from_free_r8: assert property (@(posedge clk) disable iff (rst)
    (alloc_oh != '0) |-> ((alloc_oh & free_q) == alloc_oh));

endmodule

// File: rtl/fsb_slot_state.sv
module fsb_slot_state #(
  parameter int N  = 8,
  parameter int CW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  busy,
  input  logic [N-1:0]  alloc_oh,
  input  logic [CW-1:0] alloc_color,
  input  logic [N-1:0]  rel_oh,
  input  logic          wr_fire,
  input  logic [IW-1:0] wr_idx,
  input  logic          flush_en,
  input  logic [CW-1:0] flush_color,
  output logic [N-1:0]  kill,
  output logic [N-1:0]  done_q,
  output logic [N*CW-1:0] color_q
);

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [CW-1:0] my_color;
    logic          younger;

    assign my_color = color_q[i*CW +: CW];
    assign younger  = fsb_pkg::color_younger(fsb_pkg::COLOR_MAX_W'(my_color),
                                             fsb_pkg::COLOR_MAX_W'(flush_color),
                                             CW);
    assign kill[i]  = flush_en && busy[i] && younger;

    always_ff @(posedge clk) begin
      if (rst) begin
        done_q[i]            <= 1'b0;
        color_q[i*CW +: CW]  <= '0;
      end else if (alloc_oh[i]) begin
        done_q[i]            <= 1'b0;
        color_q[i*CW +: CW]  <= alloc_color;
      end else if (rel_oh[i] || kill[i]) begin
        done_q[i]            <= 1'b0;
      end else if (wr_fire && 32'(wr_idx) == i) begin
        done_q[i]            <= 1'b1;
      end
    end

    p_flush_kill_r7: assert property (@(posedge clk) disable iff (rst)
      (flush_en && busy[i] && younger) |=> !busy[i]);

    p_done_needs_busy_r4: assert property (@(posedge clk) disable iff (rst)
      done_q[i] |-> busy[i]);
  end

endmodule

// File: rtl/fsb_payload.sv
module fsb_payload #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          wr_fire,
  input  logic [IW-1:0] wr_idx,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [N*AW-1:0] addr_flat,
  output logic [N*DW-1:0] data_flat
);

  logic [AW-1:0] addr_mem [N];
  logic [DW-1:0] data_mem [N];

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      addr_mem[wr_idx] <= wr_addr;
      data_mem[wr_idx] <= wr_data;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_flat
    assign addr_flat[i*AW +: AW] = addr_mem[i];
    assign data_flat[i*DW +: DW] = data_mem[i];
  end

endmodule

// File: rtl/finished_store_buffer.sv
module finished_store_buffer #(
  parameter int N  = 8,
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            alloc_req,
  input  logic            alloc_oldest,
  input  logic [CW-1:0]   alloc_color,
  output logic            alloc_gnt,
  output logic [IW-1:0]   alloc_idx,
  output logic            permit_young,
  output logic            permit_oldest,
  input  logic            wr_en,
  input  logic [IW-1:0]   wr_idx,
  input  logic [AW-1:0]   wr_addr,
  input  logic [DW-1:0]   wr_data,
  input  logic            ret_en,
  input  logic [IW-1:0]   ret_idx,
  input  logic            flush_en,
  input  logic [CW-1:0]   flush_color,
  output logic [N-1:0]    slot_busy,
  output logic [N-1:0]    slot_done,
  output logic [N*CW-1:0] slot_color,
  output logic [N*AW-1:0] slot_addr,
  output logic [N*DW-1:0] slot_data,
  output logic            retire_err
);

  logic [N-1:0]  free_q;
  logic [N-1:0]  rel_oh;
  logic [N-1:0]  kill;
  logic [N-1:0]  pick_oh;
  logic [N-1:0]  alloc_oh;
  logic [IW-1:0] pick_idx;
  logic          pick_found;
  logic          bad_retire;
  logic          any_free;
  logic          two_free;
  logic          grant;
  logic          wr_fire;

  fsb_pick #(.N(N), .IW(IW)) u_pick (
    .req    (free_q),
    .found  (pick_found),
    .onehot (pick_oh),
    .idx    (pick_idx)
  );

  assign grant    = alloc_req && !flush_en && pick_found &&
                    (alloc_oldest ? any_free : two_free);
  assign alloc_oh = grant ? pick_oh : '0;
  assign wr_fire  = wr_en && (32'(wr_idx) < N) && !free_q[wr_idx];

  fsb_freelist #(.N(N), .IW(IW)) u_free (
    .clk        (clk),
    .rst        (rst),
    .alloc_oh   (alloc_oh),
    .ret_en     (ret_en),
    .ret_idx    (ret_idx),
    .kill       (kill),
    .free_q     (free_q),
    .rel_oh     (rel_oh),
    .bad_retire (bad_retire),
    .any_free   (any_free),
    .two_free   (two_free)
  );

  fsb_slot_state #(.N(N), .CW(CW), .IW(IW)) u_state (
    .clk         (clk),
    .rst         (rst),
    .busy        (~free_q),
    .alloc_oh    (alloc_oh),
    .alloc_color (alloc_color),
    .rel_oh      (rel_oh),
    .wr_fire     (wr_fire),
    .wr_idx      (wr_idx),
    .flush_en    (flush_en),
    .flush_color (flush_color),
    .kill        (kill),
    .done_q      (slot_done),
    .color_q     (slot_color)
  );

  fsb_payload #(.N(N), .AW(AW), .DW(DW), .IW(IW)) u_payload (
    .clk       (clk),
    .wr_fire   (wr_fire),
    .wr_idx    (wr_idx),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .addr_flat (slot_addr),
    .data_flat (slot_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      alloc_gnt  <= 1'b0;
      alloc_idx  <= '0;
      retire_err <= 1'b0;
    end else begin
      alloc_gnt <= grant;
      if (grant) alloc_idx <= pick_idx;
      if (bad_retire) retire_err <= 1'b1;
    end
  end

  assign slot_busy     = ~free_q;
  assign permit_young  = two_free;
  assign permit_oldest = any_free;

  p_reserve_r3: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && !alloc_oldest && !permit_young) |=> !alloc_gnt);

  p_empty_refuse_r9: assert property (@(posedge clk) disable iff (rst)
    (alloc_req && slot_busy == '1) |=> !alloc_gnt);

  p_gnt_busy_r2: assert property (@(posedge clk) disable iff (rst)
    alloc_gnt |-> slot_busy[alloc_idx]);

  p_flush_no_gnt_r7: assert property (@(posedge clk) disable iff (rst)
    flush_en |=> !alloc_gnt);

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    retire_err |=> retire_err);

endmodule

// File: tb/test_finished_store_buffer.sv
module test_finished_store_buffer;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic alloc_req = 1'b0, alloc_oldest = 1'b0;
  logic [CW-1:0] alloc_color = '0;
  logic alloc_gnt;
  logic [IW-1:0] alloc_idx;
  logic permit_young, permit_oldest;
  logic wr_en = 1'b0;
  logic [IW-1:0] wr_idx = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic ret_en = 1'b0;
  logic [IW-1:0] ret_idx = '0;
  logic flush_en = 1'b0;
  logic [CW-1:0] flush_color = '0;
  logic [N-1:0] slot_busy, slot_done;
  logic [N*CW-1:0] slot_color;
  logic [N*AW-1:0] slot_addr;
  logic [N*DW-1:0] slot_data;
  logic retire_err;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  finished_store_buffer #(.N(N), .AW(AW), .DW(DW), .CW(CW), .IW(IW)) i_finished_store_buffer (
    .clk(clk), .rst(rst),
    .alloc_req(alloc_req), .alloc_oldest(alloc_oldest), .alloc_color(alloc_color),
    .alloc_gnt(alloc_gnt), .alloc_idx(alloc_idx),
    .permit_young(permit_young), .permit_oldest(permit_oldest),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_addr(wr_addr), .wr_data(wr_data),
    .ret_en(ret_en), .ret_idx(ret_idx),
    .flush_en(flush_en), .flush_color(flush_color),
    .slot_busy(slot_busy), .slot_done(slot_done), .slot_color(slot_color),
    .slot_addr(slot_addr), .slot_data(slot_data), .retire_err(retire_err)
  );

  // {oldest, colour[3:0], expected grant, expected index[2:0]}
  localparam logic [8:0] VEC [10] = '{
    {1'b0, 4'd1, 1'b1, 3'd0},
    {1'b0, 4'd2, 1'b1, 3'd1},
    {1'b0, 4'd3, 1'b1, 3'd2},
    {1'b0, 4'd4, 1'b1, 3'd3},
    {1'b0, 4'd5, 1'b1, 3'd4},
    {1'b0, 4'd6, 1'b1, 3'd5},
    {1'b0, 4'd7, 1'b1, 3'd6},
    {1'b0, 4'd8, 1'b0, 3'd0},
    {1'b1, 4'd0, 1'b1, 3'd7},
    {1'b1, 4'd2, 1'b0, 3'd0}
  };

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    alloc_req = 1'b0; wr_en = 1'b0; ret_en = 1'b0; flush_en = 1'b0;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 64'(slot_busy), 64'h0);
    chk("R1 done", 64'(slot_done), 64'h0);
    chk("R1 gnt/err", {62'd0, alloc_gnt, retire_err}, 64'h0);
    chk("R1 permits", {62'd0, permit_young, permit_oldest}, 64'h3);

    // R2/R3/R9 fill walk
    for (int v = 0; v < 10; v++) begin
      alloc_req = 1'b1;
      alloc_oldest = VEC[v][8];
      alloc_color = VEC[v][7:4];
      tick();
      alloc_req = 1'b0;
      chk($sformatf("R2 R3 gnt v%0d", v), 64'(alloc_gnt), 64'(VEC[v][3]));
      if (VEC[v][3]) chk($sformatf("R2 idx v%0d", v), 64'(alloc_idx), 64'(VEC[v][2:0]));
    end
    chk("R9 permits full", {62'd0, permit_young, permit_oldest}, 64'h0);
    chk("R2 busy full", 64'(slot_busy), 64'hFF);
    chk("R2 colour slot3", 64'(slot_color[3*CW +: CW]), 64'd4);
    chk("R2 done clear", 64'(slot_done), 64'h0);

    // R4 execute write
    wr_en = 1'b1; wr_idx = 3'd3; wr_addr = 32'hA5A5_0030; wr_data = 32'h1234_5678;
    tick(); idle();
    chk("R4 done set", 64'(slot_done[3]), 64'h1);
    chk("R4 addr", 64'(slot_addr[3*AW +: AW]), 64'hA5A5_0030);
    chk("R4 data", 64'(slot_data[3*DW +: DW]), 64'h1234_5678);

    // R5 retire
    ret_en = 1'b1; ret_idx = 3'd3;
    tick(); idle();
    chk("R5 busy", 64'(slot_busy), 64'hF7);
    chk("R5 done", 64'(slot_done[3]), 64'h0);
    chk("R5 no err", 64'(retire_err), 64'h0);

    // R6 invalid retire
    ret_en = 1'b1; ret_idx = 3'd3;
    tick(); idle();
    chk("R6 err set", 64'(retire_err), 64'h1);
    chk("R6 busy unchanged", 64'(slot_busy), 64'hF7);

    // R4 write to free slot ignored
    wr_en = 1'b1; wr_idx = 3'd3; wr_addr = 32'h0000_DEAD; wr_data = 32'h0;
    tick(); idle();
    chk("R4 free write done", 64'(slot_done[3]), 64'h0);
    chk("R4 free write addr", 64'(slot_addr[3*AW +: AW]), 64'hA5A5_0030);
    chk("R4 free write busy", 64'(slot_busy), 64'hF7);

    // R8 same-cycle alloc and retire
    alloc_req = 1'b1; alloc_oldest = 1'b1; alloc_color = 4'd0;
    ret_en = 1'b1; ret_idx = 3'd5;
    tick(); idle();
    chk("R8 gnt", 64'(alloc_gnt), 64'h1);
    chk("R8 idx", 64'(alloc_idx), 64'd3);
    chk("R8 busy", 64'(slot_busy), 64'hDF);

    // R3 last slot refused to young store
    alloc_req = 1'b1; alloc_oldest = 1'b0; alloc_color = 4'd6;
    tick(); idle();
    chk("R3 young refused", 64'(alloc_gnt), 64'h0);
    chk("R3 permits one free", {62'd0, permit_young, permit_oldest}, 64'h1);
    alloc_req = 1'b1; alloc_oldest = 1'b1; alloc_color = 4'd0;
    tick(); idle();
    chk("R3 oldest takes last", {61'd0, alloc_gnt, alloc_idx}, {61'd0, 1'b1, 3'd5});
    chk("R9 full again", 64'(slot_busy), 64'hFF);

    // R7 flush boundary 3 with concurrent request
    flush_en = 1'b1; flush_color = 4'd3;
    alloc_req = 1'b1; alloc_oldest = 1'b1; alloc_color = 4'd0;
    tick(); idle();
    chk("R7 kill younger", 64'(slot_busy), 64'hAF);
    chk("R7 no gnt in flush", 64'(alloc_gnt), 64'h0);
    chk("R6 err sticky", 64'(retire_err), 64'h1);
    alloc_req = 1'b1; alloc_oldest = 1'b0; alloc_color = 4'd9;
    tick(); idle();
    chk("R2 lowest after flush", {61'd0, alloc_gnt, alloc_idx}, {61'd0, 1'b1, 3'd4});

    // R7 flush across the wrap point, boundary 14
    flush_en = 1'b1; flush_color = 4'd14;
    tick(); idle();
    chk("R7 wrap kill", 64'(slot_busy), 64'h10);
    chk("R7 wrap done", 64'(slot_done), 64'h0);

    alloc_req = 1'b1; alloc_oldest = 1'b0; alloc_color = 4'd1;
    tick(); idle();
    chk("R2 reuse slot0", {61'd0, alloc_gnt, alloc_idx}, {61'd0, 1'b1, 3'd0});
    chk("R2 colour slot0", 64'(slot_color[0 +: CW]), 64'd1);

    // R1 reset again
    rst = 1'b1;
    tick();
    rst = 1'b0;
    chk("R1 reset busy", 64'(slot_busy), 64'h0);
    chk("R1 reset err", 64'(retire_err), 64'h0);

    finish_run();
  end

endmodule